// File: doc/BRIEF.md
# Hashed Non-Power-of-Two Channel Selector

This block maps a system physical address to the logical channel that owns it when memory is interleaved across a channel count that is not a power of two: 3, 5, 6, 10, 12 or 24 channels, each with a 1 KiB or a 2 KiB stripe. The high address bits are shifted per mode and reduced modulo 3 or modulo 5. Where the mode calls for it, the residue is combined with XOR hash bits that fold higher address bits into bits 8, 9, 12 and 13. Four enables turn on the folding at the 64 KiB, 2 MiB, 1 GiB and 1 TiB granularities.

A request is presented with a one-cycle valid strobe. The address, mode, hash enables, channel count and socket shift are captured on that edge, and the identifier with its error flag appears on the outputs, qualified by `outValid`, before the next edge. Between requests the outputs keep the last result. Unknown mode codes, and results that do not fit in 16 bits, give an identifier of zero with the error flag raised.

Top module: `nonpow2_chan_select`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high at a rising edge, and low otherwise; `outChanId` and `outErr` for that request are valid while `outValid` is high.
- R2: The modulus is 3 when `inChanCount` is a multiple of 3 (zero counts as a multiple), and 5 otherwise, whatever the mode.
- R3: The hash bits are g8 = a8^a14^(a16&e0)^(a21&e1)^(a30&e2)^(a40&e3), g9 = a9^(a17&e0)^(a22&e1)^(a31&e2)^(a41&e3), g12 = a12^(a18&e0)^(a23&e1)^(a32&e2)^(a42&e3), g13 = a13^(a19&e0)^(a24&e1)^(a33&e2)^(a43&e3), where e0..e3 are `inHashEn` bits 0..3 (64 KiB, 2 MiB, 1 GiB, 1 TiB).
- R4: Mode 10 (24 ch, 1 KiB) gives ((a[63:13]*8) mod m)*4 + g9 + 2*g12, OR g8 shifted left by `inSockShift`; mode 11 (24 ch, 2 KiB) gives ((a[63:14]*16) mod m)*4 + g12 + 2*g13, OR g8 shifted left by `inSockShift`.
- R5: Mode 8 (12 ch, 1 KiB) gives ((a[63:12]*4) mod m)*4 + g8 + 2*g9; mode 9 (12 ch, 2 KiB) gives ((a[63:13]*8) mod m)*4 + g8 + 2*g12.
- R6: Modes 4 and 6 (6 and 10 ch, 1 KiB) give ((a[63:12]*4 + 2*a9) mod m)*2 + g8; modes 5 and 7 (6 and 10 ch, 2 KiB) give ((a[63:12]*4) mod m)*2 + g8.
- R7: Modes 0 and 2 (3 and 5 ch, 1 KiB) give (a[63:12]*4 + a[9:8]) mod m; modes 1 and 3 (3 and 5 ch, 2 KiB) give (a[63:12]*4 + 2*a8) mod m; no hash bit enters these modes.
- R8: Mode codes 12 to 15 give `outChanId` = 0 and `outErr` = 1.
- R9: When the packed result has any bit set above bit 15 (possible when g8 is shifted by 16 or more), `outChanId` is 0 and `outErr` is 1; a shift of 15 yields bit 15 with no error.
- R10: While `inValid` is low, `outChanId` and `outErr` keep their last values.
- R11: After reset, `outValid`, `outChanId` and `outErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; captures all request inputs |
| inAddr | input | 64 | System physical address |
| inMode | input | 4 | Interleave mode code (0 to 11 valid) |
| inHashEn | input | 4 | Hash folding enables: bit0 64 KiB, bit1 2 MiB, bit2 1 GiB, bit3 1 TiB |
| inChanCount | input | 6 | Number of interleaved channels; selects the modulus |
| inSockShift | input | 5 | Left shift applied to g8 in the 24-channel modes |
| outValid | output | 1 | Result qualifier, one cycle after the request |
| outChanId | output | 16 | Logical channel identifier |
| outErr | output | 1 | Unknown mode or identifier overflow |

## Verification
The hardest case to reach is a hash bit that is set only by folding from a high granularity bit. Such a case needs an address with a single bit at 16 or 40 and exactly the matching enable. It also needs a mode whose residue of the remaining bits is known, so that a flipped g8 shows as a one-count change in the identifier. Directed vectors pin this case with and without the enable. Overflow is reached through the 24-channel 1 KiB mode with only address bit 8 set, at shifts 15 and 16. A further sweep of generated addresses, modes and shifts covers the folding of the residue across the whole dividend width.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  localparam int HCS_ADDR_W = 64;

  // Interleave mode codes; the numeric values are part of the port contract.
  typedef enum logic [3:0] {
    MODE_C3_1K  = 4'd0,
    MODE_C3_2K  = 4'd1,
    MODE_C5_1K  = 4'd2,
    MODE_C5_2K  = 4'd3,
    MODE_C6_1K  = 4'd4,
    MODE_C6_2K  = 4'd5,
    MODE_C10_1K = 4'd6,
    MODE_C10_2K = 4'd7,
    MODE_C12_1K = 4'd8,
    MODE_C12_2K = 4'd9,
    MODE_C24_1K = 4'd10,
    MODE_C24_2K = 4'd11
  } hcsMode_e;

  localparam logic [3:0] MODE_LAST = 4'd11;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
  } hcsStrobe_t;

  // One XOR-folded hash bit: base bit plus four gated granularity bits.
  function automatic logic foldHash(input logic [HCS_ADDR_W-1:0] a,
                                    input int baseBit,
                                    input int p64k, input int p2m,
                                    input int p1g,  input int p1t,
                                    input logic [3:0] en);
    return a[baseBit] ^ (a[p64k] & en[0]) ^ (a[p2m] & en[1]) ^
           (a[p1g] & en[2]) ^ (a[p1t] & en[3]);
  endfunction

  // Final reduction of an already-folded small value.
  function automatic logic [2:0] reduceSmall(input logic [5:0] v,
                                             input logic [5:0] m);
    logic [5:0] r;
    r = v;
    for (int i = 0; i < 16; i++) begin
      if (r >= m) r = r - m;
    end
    return r[2:0];
  endfunction

endpackage

// File: rtl/hcs_residue.sv
// Combinational residue modulo 3 or 5 of a wide value by digit folding:
// 4 = 1 (mod 3) so base-4 digits are summed; 16 = 1 (mod 5) so base-16
// digits are summed. Two folds bring the value under 64.
module hcs_residue
  import hcs_pkg::*;
#(
  parameter int DIV_W = 54
) (
  input  logic [DIV_W-1:0] divIn,
  input  logic             useFive,
  output logic [2:0]       residue
);

  localparam int N4   = (DIV_W + 1) / 2;
  localparam int N16  = (DIV_W + 3) / 4;
  localparam int PAD4 = N4 * 2;
  localparam int PAD16 = N16 * 4;

  logic [PAD4-1:0]  v4;
  logic [PAD16-1:0] v16;
  logic [15:0]      sum3a, sum5a;
  logic [5:0]       sum3b, sum5b;
  logic [2:0]       res3, res5;

  assign v4  = PAD4'(divIn);
  assign v16 = PAD16'(divIn);

  // First fold: one adder chain per modulus, one term per digit.
  always_comb begin
    sum3a = '0;
    for (int i = 0; i < N4; i++) sum3a = sum3a + 16'(v4[2*i +: 2]);
  end

  always_comb begin
    sum5a = '0;
    for (int i = 0; i < N16; i++) sum5a = sum5a + 16'(v16[4*i +: 4]);
  end

  // Second fold over the 16-bit partial sums.
  always_comb begin
    sum3b = '0;
    for (int i = 0; i < 8; i++) sum3b = sum3b + 6'(sum3a[2*i +: 2]);
  end

  always_comb begin
    sum5b = '0;
    for (int i = 0; i < 4; i++) sum5b = sum5b + 6'(sum5a[4*i +: 4]);
  end

  assign res3    = reduceSmall(sum3b, 6'd3);
  assign res5    = reduceSmall(sum5b, 6'd5);
  assign residue = useFive ? res5 : res3;

endmodule

// File: rtl/hcs_ctrl.sv
module hcs_ctrl
  import hcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output hcsStrobe_t strobe,
  output logic       outValid
);

  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1: result qualifier follows the request by exactly one cycle
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/hcs_datapath.sv
module hcs_datapath
  import hcs_pkg::*;
#(
  parameter int ADDR_W  = HCS_ADDR_W,
  parameter int ID_W    = 16,
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  hcsStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [3:0]         modeIn,
  input  logic [3:0]         hashEnIn,
  input  logic [CNT_W-1:0]   chanCountIn,
  input  logic [SHIFT_W-1:0] sockShiftIn,
  output logic [ID_W-1:0]    chanId,
  output logic               idErr
);

  localparam int DIV_W  = ADDR_W - 10;
  localparam int WIDE_W = ID_W + (1 << SHIFT_W);

  // Captured request
  logic [ADDR_W-1:0]  addrQ;
  logic [3:0]         modeQ;
  logic [3:0]         hashEnQ;
  logic [CNT_W-1:0]   chanCountQ;
  logic [SHIFT_W-1:0] sockShiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      modeQ      <= '0;
      hashEnQ    <= '0;
      chanCountQ <= '0;
      sockShiftQ <= '0;
    end else if (strobe.capture) begin
      addrQ      <= addrIn;
      modeQ      <= modeIn;
      hashEnQ    <= hashEnIn;
      chanCountQ <= chanCountIn;
      sockShiftQ <= sockShiftIn;
    end
  end

  // Bits 7:0 and 11:10 never steer the channel.
  logic unusedAddrBits;
  assign unusedAddrBits = ^{addrQ[7:0], addrQ[11:10]};

  // Modulus selection: residue of the channel count modulo 3.
  logic [2:0] cntRes;
  logic       useFive;

  hcs_residue #(.DIV_W(CNT_W)) uCntRes (
    .divIn   (chanCountQ),
    .useFive (1'b0),
    .residue (cntRes)
  );

  assign useFive = (cntRes != 3'd0);

  // Hash bits
  logic g8, g9, g12, g13;
  assign g8  = foldHash(addrQ, 8, 16, 21, 30, 40, hashEnQ) ^ addrQ[14];
  assign g9  = foldHash(addrQ, 9, 17, 22, 31, 41, hashEnQ);
  assign g12 = foldHash(addrQ, 12, 18, 23, 32, 42, hashEnQ);
  assign g13 = foldHash(addrQ, 13, 19, 24, 33, 43, hashEnQ);

  // Per-mode dividend
  logic [DIV_W-1:0] dividend;
  logic             badMode;

  always_comb begin
    dividend = '0;
    badMode  = 1'b0;
    unique case (modeQ)
      MODE_C24_1K,
      MODE_C12_2K:               dividend = {addrQ[ADDR_W-1:13], 3'b000};
      MODE_C24_2K:               dividend = {addrQ[ADDR_W-1:14], 4'b0000};
      MODE_C12_1K,
      MODE_C6_2K, MODE_C10_2K:   dividend = {addrQ[ADDR_W-1:12], 2'b00};
      MODE_C6_1K, MODE_C10_1K:   dividend = {addrQ[ADDR_W-1:12], addrQ[9], 1'b0};
      MODE_C3_1K, MODE_C5_1K:    dividend = {addrQ[ADDR_W-1:12], addrQ[9:8]};
      MODE_C3_2K, MODE_C5_2K:    dividend = {addrQ[ADDR_W-1:12], addrQ[8], 1'b0};
      default:                   badMode  = 1'b1;
    endcase
  end

  logic [2:0] divRes;

  hcs_residue #(.DIV_W(DIV_W)) uDivRes (
    .divIn   (dividend),
    .useFive (useFive),
    .residue (divRes)
  );

  // Packing
  logic [WIDE_W-1:0] wideId;
  logic [WIDE_W-1:0] sockBit;
  logic              overflow;

  assign sockBit = WIDE_W'(g8) << sockShiftQ;

  always_comb begin
    wideId = '0;
    unique case (modeQ)
      MODE_C24_1K: wideId = (WIDE_W'(divRes) << 2) | WIDE_W'({g12, g9})  | sockBit;
      MODE_C24_2K: wideId = (WIDE_W'(divRes) << 2) | WIDE_W'({g13, g12}) | sockBit;
      MODE_C12_1K: wideId = (WIDE_W'(divRes) << 2) | WIDE_W'({g9, g8});
      MODE_C12_2K: wideId = (WIDE_W'(divRes) << 2) | WIDE_W'({g12, g8});
      MODE_C6_1K, MODE_C6_2K,
      MODE_C10_1K, MODE_C10_2K:
                   wideId = (WIDE_W'(divRes) << 1) | WIDE_W'(g8);
      MODE_C3_1K, MODE_C3_2K,
      MODE_C5_1K, MODE_C5_2K:
                   wideId = WIDE_W'(divRes);
      default:     wideId = '0;
    endcase
  end

  assign overflow = |wideId[WIDE_W-1:ID_W];
  assign idErr    = badMode | overflow;
  assign chanId   = idErr ? '0 : wideId[ID_W-1:0];

  // R2: residue stays below the chosen modulus
  p_res_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    divRes < (useFive ? 3'd5 : 3'd3));

  // R7: narrow modes never exceed the largest residue and never flag
  p_narrow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ <= MODE_C5_2K) |-> (!idErr && chanId < ID_W'(5)));

  // R8: codes above the last valid mode give zero with the flag
  p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ > MODE_LAST) |-> (idErr && chanId == '0));

  // R9: g8 shifted past the identifier width raises the flag
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_C24_1K || modeQ == MODE_C24_2K) && g8 &&
     (32'(sockShiftQ) >= ID_W)) |-> (idErr && chanId == '0));

  // R10: no capture, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(chanId) && $stable(idErr)));

endmodule

// File: rtl/nonpow2_chan_select.sv
module nonpow2_chan_select
  import hcs_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [HCS_ADDR_W-1:0] inAddr,
  input  logic [3:0]            inMode,
  input  logic [3:0]            inHashEn,
  input  logic [CNT_W-1:0]      inChanCount,
  input  logic [SHIFT_W-1:0]    inSockShift,
  output logic                  outValid,
  output logic [ID_W-1:0]       outChanId,
  output logic                  outErr
);

  hcsStrobe_t strobe;

  hcs_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hcs_datapath #(
    .ADDR_W  (HCS_ADDR_W),
    .ID_W    (ID_W),
    .CNT_W   (CNT_W),
    .SHIFT_W (SHIFT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addrIn      (inAddr),
    .modeIn      (inMode),
    .hashEnIn    (inHashEn),
    .chanCountIn (inChanCount),
    .sockShiftIn (inSockShift),
    .chanId      (outChanId),
    .idErr       (outErr)
  );

  // R11: reset state is quiet (checked one cycle after reset release)
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outChanId == '0 && !outErr));

endmodule

// File: tb/nonpow2_chan_select_test.sv
module nonpow2_chan_select_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inAddr = '0;
  logic [3:0]  inMode = '0;
  logic [3:0]  inHashEn = '0;
  logic [5:0]  inChanCount = '0;
  logic [4:0]  inSockShift = '0;
  logic        outValid;
  logic [15:0] outChanId;
  logic        outErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nonpow2_chan_select uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .inMode(inMode), .inHashEn(inHashEn), .inChanCount(inChanCount),
    .inSockShift(inSockShift), .outValid(outValid), .outChanId(outChanId),
    .outErr(outErr)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic [3:0]  mode;
    logic [3:0]  en;
    logic [5:0]  cnt;
    logic [4:0]  sh;
    logic [15:0] expId;
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{64'h1000,      4'd0,  4'h0, 6'd3,  5'd0,  16'd1,      1'b0, 8'd7}, // R7 3ch 1K
    '{64'h1000,      4'd0,  4'h0, 6'd5,  5'd0,  16'd4,      1'b0, 8'd2}, // R2 count picks mod 5
    '{64'h3100,      4'd3,  4'h0, 6'd5,  5'd0,  16'd4,      1'b0, 8'd7}, // R7 5ch 2K
    '{64'h2000,      4'd10, 4'h0, 6'd24, 5'd5,  16'd8,      1'b0, 8'd4}, // R4 24ch 1K
    '{64'h3000,      4'd11, 4'h0, 6'd24, 5'd4,  16'd3,      1'b0, 8'd4}, // R4 24ch 2K
    '{64'h10000,     4'd8,  4'h1, 6'd12, 5'd0,  16'd5,      1'b0, 8'd3}, // R3 64K fold on
    '{64'h10000,     4'd8,  4'h0, 6'd12, 5'd0,  16'd4,      1'b0, 8'd5}, // R5 fold off
    '{64'h1100,      4'd9,  4'h0, 6'd12, 5'd0,  16'd3,      1'b0, 8'd5}, // R5 12ch 2K
    '{64'h100_0000_0000, 4'd5, 4'h8, 6'd6, 5'd0, 16'd3,     1'b0, 8'd6}, // R3 1T fold, R6
    '{64'h200,       4'd6,  4'h0, 6'd10, 5'd0,  16'd4,      1'b0, 8'd6}, // R6 10ch 1K
    '{64'h100,       4'd10, 4'h0, 6'd24, 5'd16, 16'd0,      1'b1, 8'd9}, // R9 overflow
    '{64'h100,       4'd10, 4'h0, 6'd24, 5'd15, 16'h8000,   1'b0, 8'd9}, // R9 top bit fits
    '{64'h12345678,  4'd13, 4'hF, 6'd24, 5'd0,  16'd0,      1'b1, 8'd8}  // R8 bad mode
  };

  function automatic logic hb(input logic [63:0] a, input int b, input int p0,
                              input int p1, input int p2, input int p3,
                              input logic [3:0] e);
    return a[b] ^ (a[p0] & e[0]) ^ (a[p1] & e[1]) ^ (a[p2] & e[2]) ^ (a[p3] & e[3]);
  endfunction

  // Reference model written from the requirements.
  task automatic model(input logic [63:0] a, input logic [3:0] md,
                       input logic [3:0] e, input logic [5:0] c,
                       input logic [4:0] s, output logic [15:0] id,
                       output logic err);
    longint unsigned m, d, w;
    logic h8, h9, h12, h13;
    m   = (c % 3 == 0) ? 3 : 5;
    h8  = hb(a, 8, 16, 21, 30, 40, e) ^ a[14];
    h9  = hb(a, 9, 17, 22, 31, 41, e);
    h12 = hb(a, 12, 18, 23, 32, 42, e);
    h13 = hb(a, 13, 19, 24, 33, 43, e);
    err = 1'b0;
    w   = 0;
    case (md)
      4'd10: begin d = (a >> 13) << 3; w = ((d % m) << 2) | h9 | (h12 << 1) | (longint'(h8) << s); end
      4'd11: begin d = (a >> 14) << 4; w = ((d % m) << 2) | h12 | (h13 << 1) | (longint'(h8) << s); end
      4'd8:  begin d = (a >> 12) << 2; w = ((d % m) << 2) | h8 | (h9 << 1); end
      4'd9:  begin d = (a >> 13) << 3; w = ((d % m) << 2) | h8 | (h12 << 1); end
      4'd4, 4'd6: begin d = ((a >> 12) << 2) | (a[9] << 1); w = ((d % m) << 1) | h8; end
      4'd5, 4'd7: begin d = (a >> 12) << 2; w = ((d % m) << 1) | h8; end
      4'd0, 4'd2: begin d = ((a >> 12) << 2) | a[9:8]; w = d % m; end
      4'd1, 4'd3: begin d = ((a >> 12) << 2) | (a[8] << 1); w = d % m; end
      default: err = 1'b1;
    endcase
    if (w > 64'hFFFF) err = 1'b1;
    id = err ? 16'd0 : w[15:0];
  endtask

  task automatic check(input bit ok, input string req, input longint unsigned got,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic runOne(input logic [63:0] a, input logic [3:0] md,
                        input logic [3:0] e, input logic [5:0] c,
                        input logic [4:0] s, input logic [15:0] expId,
                        input logic expErr, input string req);
    @(negedge clk);
    inAddr = a; inMode = md; inHashEn = e; inChanCount = c; inSockShift = s;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R1 valid", outValid, 1);
    check(outChanId == expId, req, outChanId, expId);
    check(outErr == expErr, {req, " err"}, outErr, expErr);
  endtask

  initial begin
    logic [15:0] eId;
    logic        eErr;
    logic [63:0] lfsr;
    logic [15:0] heldId;
    logic        heldErr;

    repeat (3) @(negedge clk);
    // R11: reset values
    check(outValid == 1'b0, "R11 valid", outValid, 0);
    check(outChanId == 16'd0, "R11 id", outChanId, 0);
    check(outErr == 1'b0, "R11 err", outErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle", outValid, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      runOne(VECS[i].addr, VECS[i].mode, VECS[i].en, VECS[i].cnt, VECS[i].sh,
             VECS[i].expId, VECS[i].expErr, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R10: inputs change without a strobe; outputs hold
    heldId = outChanId; heldErr = outErr;
    @(negedge clk);
    inAddr = 64'hFFFF_FFFF_FFFF_FFFF; inMode = 4'd8; inHashEn = 4'hF;
    inChanCount = 6'd12; inSockShift = 5'd3;
    @(negedge clk);
    check(outValid == 1'b0, "R1 no strobe", outValid, 0);
    check(outChanId == heldId, "R10 id hold", outChanId, heldId);
    check(outErr == heldErr, "R10 err hold", outErr, heldErr);

    // Generated sweep against the model (R3 R4 R5 R6 R7 R8 R9)
    lfsr = 64'hACE1_2468_9BDF_1357;
    for (int i = 0; i < 60; i++) begin
      logic [3:0] md;
      logic [5:0] c;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = lfsr ^ (lfsr << 17) ^ 64'(i * 32'h9E37_79B9);
      md = 4'(i % 14);
      case (i % 6)
        0: c = 6'd3;  1: c = 6'd5;  2: c = 6'd6;
        3: c = 6'd10; 4: c = 6'd12; default: c = 6'd24;
      endcase
      model(lfsr, md, 4'(i), c, 5'(i % 20), eId, eErr);
      runOne(lfsr, md, 4'(i), c, 5'(i % 20), eId, eErr,
             $sformatf("R4-sweep mode%0d i%0d", md, i));
    end

    // R11: reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outChanId == 16'd0 && outErr == 1'b0,
          "R11 re-reset", {outValid, outChanId, outErr}, 0);
    rstN = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule